// File: doc/BRIEF.md
# Ten-bit ECC spare-area codec

This block moves eight 10-bit error-correction symbols between the form in which an ECC engine captures them and the ten-byte form in which they are stored in a flash page's spare area. On the pack side it takes four 32-bit capture words. Each word carries two symbols, and any other bits in the word are discarded. The block folds the symbols into a dense 80-bit image in two passes. Each pass handles two words and produces five bytes.

On the unpack side it takes the ten stored bytes. If every byte reads 0xFF, the page has never been programmed. In that case the block raises an erased flag and issues nothing for checking. Otherwise it separates the image into its eight symbols and sends them to a downstream syndrome engine one per cycle, from the highest-numbered symbol down to symbol 0.

The two sides are independent. Each has its own start pulse, busy level and done pulse, so a write-path pack and a read-path unpack may overlap.

Top module: `ecc10_spare_codec`

## Requirements
- R1: After synchronous reset, `pk_busy`, `pk_done`, `pk_bytes`, `up_busy`, `up_done`, `up_erased`, `up_sym_valid`, `up_sym` and `up_sym_idx` are all zero.
- R2: Only bits 9:0 and 25:16 of each capture word affect the packed image. Bits 15:10 and 31:26 have no effect.
- R3: Capture word k (at `pk_words[32k+31:32k]`) supplies symbol 2k from its bits 9:0 and symbol 2k+1 from its bits 25:16. Bit b of symbol i lands at bit 10i+b of the image. Byte j of the image is `pk_bytes[8j+7:8j]`, so bytes 0..4 come from words 0 and 1 and bytes 5..9 come from words 2 and 3.
- R4: `pk_busy` is high from the cycle after an accepted `pk_start` up to the cycle before `pk_done`. `pk_done` is a one-cycle pulse seen two cycles after the start edge, carrying the complete image. `pk_bytes` then holds that image until the next accepted start.
- R5: When all ten bytes of `up_bytes` (byte j at `up_bytes[8j+7:8j]`) equal 0xFF at an accepted `up_start`, `up_done` and `up_erased` are high in the next cycle and `up_sym_valid` stays low for the whole operation.
- R6: For any other image, `up_sym_valid` is high for eight consecutive cycles starting one cycle after the start edge. `up_sym_idx` runs 7, 6, … 0, and `up_sym` equals image bits [10i+9:10i] for index i.
- R7: For a non-erased image, `up_done` pulses in the same cycle as the symbol with index 0, and `up_erased` reads 0 from the cycle after the start edge.
- R8: A start pulse on either side while that side is busy is ignored. The operation in flight finishes with its original data.
- R9: Packing four capture words and unpacking the resulting ten bytes returns the original eight symbols, provided at least one byte is not 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pk_start | input | 1 | Start a pack of `pk_words` |
| pk_words | input | 128 | Four 32-bit capture words, word k at bits 32k+31:32k |
| pk_busy | output | 1 | Pack in progress |
| pk_done | output | 1 | One-cycle pulse: packed image complete |
| pk_bytes | output | 80 | Packed ten-byte image, byte j at bits 8j+7:8j |
| up_start | input | 1 | Start an unpack of `up_bytes` |
| up_bytes | input | 80 | Stored ten-byte image |
| up_busy | output | 1 | Symbols still being issued |
| up_done | output | 1 | One-cycle pulse: unpack finished |
| up_erased | output | 1 | Last unpacked image was all 0xFF |
| up_sym_valid | output | 1 | `up_sym` carries a symbol this cycle |
| up_sym | output | 10 | Unpacked symbol |
| up_sym_idx | output | 3 | Index of the symbol on `up_sym` |

## Verification
The bench aims at the bit interleave across word boundaries. It uses random capture words with set junk bits, so a packer that leaked bits 15:10 or 31:26, or that swapped the two symbols of a word, would produce the wrong bytes. For erase detection it tries an all-0xFF image and an image with a single cleared bit. A detector that tested fewer than ten bytes, or that was inverted, would issue symbols for a blank page or stay silent on a real one. A stray start pulse lands mid-flight on both sides, which catches a design that restarts and changes its output. Reversed or shifted issue order, a done pulse one cycle early or late, and a symbol-0 mismatch on the round trip are checked cycle by cycle.

// File: rtl/ecc10_pkg.sv
package ecc10_pkg;

    localparam int SYM_W_DEF  = 10;
    localparam int SYMS_DEF   = 8;
    localparam int WORD_W_DEF = 32;
    localparam int HI_LSB_DEF = 16;

    typedef enum logic [1:0] {
        UP_IDLE  = 2'd0,
        UP_EMIT  = 2'd1
    } up_state_e;

    typedef struct packed {
        logic       valid;
        logic [2:0] idx;
        logic [9:0] value;
    } sym_beat_t;

    function automatic int ceil_log2(input int n);
        int r;
        r = 0;
        while ((1 << r) < n) r++;
        return (r < 1) ? 1 : r;
    endfunction

endpackage

// File: rtl/ecc10_packer.sv
module ecc10_packer
    import ecc10_pkg::*;
#(
    parameter int SYM_W  = SYM_W_DEF,
    parameter int SYMS   = SYMS_DEF,
    parameter int WORD_W = WORD_W_DEF,
    parameter int HI_LSB = HI_LSB_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [SYMS/2*WORD_W-1:0]  words,
    output logic                      busy,
    output logic                      done,
    output logic [SYMS*SYM_W-1:0]     image
);
    localparam int WORDS   = SYMS / 2;
    localparam int PASSES  = 2;
    localparam int SPP     = SYMS / PASSES;
    localparam int PASS_W  = SPP * SYM_W;
    localparam int IMG_W   = SYMS * SYM_W;
    localparam int PCNT_W  = ceil_log2(PASSES);

    logic [WORDS*WORD_W-1:0] word_q;
    logic [PCNT_W-1:0]       pass_q;
    logic                    busy_q;
    logic                    done_q;
    logic [IMG_W-1:0]        image_q;

    logic [SYM_W-1:0]  sym_arr [SYMS];
    logic [PASS_W-1:0] pass_bits;

    // Each word gives up two symbols; all other bits are dropped here.
    for (genvar k = 0; k < WORDS; k++) begin : g_split
        assign sym_arr[2*k]   = word_q[k*WORD_W +: SYM_W];
        assign sym_arr[2*k+1] = word_q[k*WORD_W + HI_LSB +: SYM_W];
    end

    always_comb begin
        pass_bits = '0;
        for (int j = 0; j < SPP; j++) begin
            pass_bits[j*SYM_W +: SYM_W] = sym_arr[int'(pass_q)*SPP + j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            pass_q  <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            image_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                word_q <= words;
                pass_q <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                image_q[int'(pass_q)*PASS_W +: PASS_W] <= pass_bits;
                if (int'(pass_q) == PASSES - 1) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    pass_q <= pass_q + 1'b1;
                end
            end
        end
    end

    assign busy  = busy_q;
    assign done  = done_q;
    assign image = image_q;

    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(busy_q));
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    a_r4_two_passes: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |=> busy_q);
    a_r8_words_held: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(word_q));
    a_r4_image_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !$past(busy_q)) |-> $stable(image_q));

endmodule

// File: rtl/ecc10_erase_check.sv
module ecc10_erase_check #(
    parameter int BYTES = 10
) (
    input  logic [BYTES*8-1:0] image,
    output logic               erased
);
    logic [BYTES-1:0] byte_blank;

    for (genvar j = 0; j < BYTES; j++) begin : g_byte
        assign byte_blank[j] = &image[j*8 +: 8];
    end

    assign erased = &byte_blank;

endmodule

// File: rtl/ecc10_unpacker.sv
module ecc10_unpacker
    import ecc10_pkg::*;
#(
    parameter int SYM_W = SYM_W_DEF,
    parameter int SYMS  = SYMS_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [SYMS*SYM_W-1:0]      image,
    input  logic                       blank,
    output logic                       busy,
    output logic                       done,
    output logic                       erased,
    output logic                       sym_valid,
    output logic [SYM_W-1:0]           sym,
    output logic [ceil_log2(SYMS)-1:0] sym_idx
);
    localparam int IMG_W = SYMS * SYM_W;
    localparam int IDX_W = ceil_log2(SYMS);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(SYMS - 1);

    up_state_e        state_q;
    logic [IDX_W-1:0] cnt_q;
    logic [IMG_W-1:0] img_q;
    logic             done_q;
    logic             erased_q;
    logic             valid_q;
    logic [SYM_W-1:0] sym_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= UP_IDLE;
            cnt_q    <= '0;
            img_q    <= '0;
            done_q   <= 1'b0;
            erased_q <= 1'b0;
            valid_q  <= 1'b0;
            sym_q    <= '0;
            idx_q    <= '0;
        end else begin
            done_q  <= 1'b0;
            valid_q <= 1'b0;
            case (state_q)
                UP_IDLE: begin
                    if (start) begin
                        img_q    <= image;
                        erased_q <= blank;
                        if (blank) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= UP_EMIT;
                            cnt_q   <= TOP_IDX;
                        end
                    end
                end
                UP_EMIT: begin
                    valid_q <= 1'b1;
                    sym_q   <= img_q[int'(cnt_q)*SYM_W +: SYM_W];
                    idx_q   <= cnt_q;
                    if (cnt_q == '0) begin
                        state_q <= UP_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= UP_IDLE;
            endcase
        end
    end

    assign busy      = (state_q == UP_EMIT);
    assign done      = done_q;
    assign erased    = erased_q;
    assign sym_valid = valid_q;
    assign sym       = sym_q;
    assign sym_idx   = idx_q;

    a_r5_blank_silent: assert property (@(posedge clk) disable iff (rst)
        erased_q |-> !valid_q);
    a_r6_descending: assert property (@(posedge clk) disable iff (rst)
        (valid_q && $past(valid_q)) |-> (idx_q == $past(idx_q) - 1'b1));
    a_r6_first_top: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !$past(valid_q)) |-> (idx_q == TOP_IDX));
    a_r7_done_last: assert property (@(posedge clk) disable iff (rst)
        (done_q && !erased_q) |-> (valid_q && idx_q == '0));
    a_r8_image_held: assert property (@(posedge clk) disable iff (rst)
        (state_q == UP_EMIT && $past(state_q) == UP_EMIT) |-> $stable(img_q));

endmodule

// File: rtl/ecc10_spare_codec.sv
module ecc10_spare_codec
    import ecc10_pkg::*;
#(
    parameter int SYM_W  = SYM_W_DEF,
    parameter int SYMS   = SYMS_DEF,
    parameter int WORD_W = WORD_W_DEF,
    parameter int HI_LSB = HI_LSB_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pk_start,
    input  logic [SYMS/2*WORD_W-1:0]     pk_words,
    output logic                         pk_busy,
    output logic                         pk_done,
    output logic [SYMS*SYM_W-1:0]        pk_bytes,
    input  logic                         up_start,
    input  logic [SYMS*SYM_W-1:0]        up_bytes,
    output logic                         up_busy,
    output logic                         up_done,
    output logic                         up_erased,
    output logic                         up_sym_valid,
    output logic [SYM_W-1:0]             up_sym,
    output logic [ceil_log2(SYMS)-1:0]   up_sym_idx
);
    localparam int BYTES = SYMS * SYM_W / 8;

    logic blank;

    ecc10_packer #(
        .SYM_W(SYM_W), .SYMS(SYMS), .WORD_W(WORD_W), .HI_LSB(HI_LSB)
    ) u_pack (
        .clk   (clk),
        .rst   (rst),
        .start (pk_start),
        .words (pk_words),
        .busy  (pk_busy),
        .done  (pk_done),
        .image (pk_bytes)
    );

    ecc10_erase_check #(.BYTES(BYTES)) u_blank (
        .image  (up_bytes),
        .erased (blank)
    );

    ecc10_unpacker #(.SYM_W(SYM_W), .SYMS(SYMS)) u_unpack (
        .clk       (clk),
        .rst       (rst),
        .start     (up_start),
        .image     (up_bytes),
        .blank     (blank),
        .busy      (up_busy),
        .done      (up_done),
        .erased    (up_erased),
        .sym_valid (up_sym_valid),
        .sym       (up_sym),
        .sym_idx   (up_sym_idx)
    );

endmodule

// File: tb/sim_ecc10_spare_codec.sv
module sim_ecc10_spare_codec;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pk_start = 1'b0;
    logic [127:0] pk_words = '0;
    logic         pk_busy, pk_done;
    logic [79:0]  pk_bytes;
    logic         up_start = 1'b0;
    logic [79:0]  up_bytes = '0;
    logic         up_busy, up_done, up_erased, up_sym_valid;
    logic [9:0]   up_sym;
    logic [2:0]   up_sym_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc10_spare_codec u0 (
        .clk(clk), .rst(rst),
        .pk_start(pk_start), .pk_words(pk_words), .pk_busy(pk_busy),
        .pk_done(pk_done), .pk_bytes(pk_bytes),
        .up_start(up_start), .up_bytes(up_bytes), .up_busy(up_busy),
        .up_done(up_done), .up_erased(up_erased), .up_sym_valid(up_sym_valid),
        .up_sym(up_sym), .up_sym_idx(up_sym_idx)
    );

    task automatic chk(input bit ok, input string req, input logic [79:0] act,
                       input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Spec image: word k low field -> symbol 2k, high field -> symbol 2k+1,
    // symbol i bit b -> image bit 10i+b.
    function automatic logic [79:0] ref_image(input logic [127:0] w);
        logic [79:0] img;
        for (int k = 0; k < 4; k++) begin
            for (int b = 0; b < 10; b++) begin
                img[20*k + b]      = w[32*k + b];
                img[20*k + 10 + b] = w[32*k + 16 + b];
            end
        end
        return img;
    endfunction

    function automatic logic [9:0] ref_sym(input logic [127:0] w, input int i);
        return (i % 2 == 0) ? w[32*(i/2) +: 10] : w[32*(i/2) + 16 +: 10];
    endfunction

    // R4/R8: pack with optional stray start one cycle into the operation.
    task automatic run_pack(input logic [127:0] w, input bit stray);
        logic [79:0] exp;
        exp = ref_image(w);
        @(negedge clk); pk_start = 1'b1; pk_words = w;
        @(negedge clk);
        pk_start = stray;
        if (stray) pk_words = ~w;
        chk(pk_busy === 1'b1 && pk_done === 1'b0, "R4 busy after start", {78'd0, pk_busy, pk_done}, 80'h2);
        @(negedge clk); pk_start = 1'b0;
        chk(pk_done === 1'b0, "R4 no early done", {79'd0, pk_done}, 80'd0);
        @(negedge clk);
        chk(pk_done === 1'b1 && pk_busy === 1'b0, "R4 done pulse", {78'd0, pk_busy, pk_done}, 80'h1);
        chk(pk_bytes === exp, stray ? "R8 pack stray start ignored" : "R3 packed image", pk_bytes, exp);
        @(negedge clk);
        chk(pk_done === 1'b0 && pk_bytes === exp, "R4 pulse ends, bytes held", {pk_done, pk_bytes[78:0]}, {1'b0, exp[78:0]});
    endtask

    // R5/R6/R7/R8: unpack; expected symbols taken from img.
    task automatic run_unpack(input logic [79:0] img, input bit stray, input string tag);
        bit blank;
        blank = (img == {80{1'b1}});
        @(negedge clk); up_start = 1'b1; up_bytes = img;
        @(negedge clk); up_start = 1'b0;
        if (blank) begin
            chk(up_done === 1'b1 && up_erased === 1'b1 && up_sym_valid === 1'b0,
                "R5 erased done", {77'd0, up_done, up_erased, up_sym_valid}, 80'h6);
            @(negedge clk);
            chk(up_done === 1'b0 && up_sym_valid === 1'b0 && up_busy === 1'b0,
                "R5 no symbols issued", {77'd0, up_done, up_sym_valid, up_busy}, 80'd0);
        end else begin
            chk(up_erased === 1'b0 && up_sym_valid === 1'b0, "R7 not erased",
                {78'd0, up_erased, up_sym_valid}, 80'd0);
            for (int k = 0; k < 8; k++) begin
                int i;
                i = 7 - k;
                if (stray && k == 2) begin up_start = 1'b1; up_bytes = ~img; end
                @(negedge clk);
                up_start = 1'b0;
                chk(up_sym_valid === 1'b1 && up_sym_idx === 3'(i) && up_sym === img[10*i +: 10],
                    stray ? "R8 unpack stray start ignored" : tag,
                    {66'd0, up_sym_valid, up_sym_idx, up_sym}, {66'd0, 1'b1, 3'(i), img[10*i +: 10]});
                chk(up_done === (k == 7), "R7 done with last symbol", {79'd0, up_done}, {79'd0, k == 7});
            end
            @(negedge clk);
            chk(up_sym_valid === 1'b0 && up_done === 1'b0, "R6 exactly eight symbols",
                {78'd0, up_sym_valid, up_done}, 80'd0);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0A17));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pk_busy === 0 && pk_done === 0 && pk_bytes === '0 && up_busy === 0 && up_done === 0
            && up_erased === 0 && up_sym_valid === 0 && up_sym === '0 && up_sym_idx === '0,
            "R1 reset state", pk_bytes, 80'd0);

        // R3 directed: distinct symbols 1..8
        run_pack({32'h0008_0007, 32'h0006_0005, 32'h0004_0003, 32'h0002_0001}, 0);
        // R2: junk-only bits give a zero image
        run_pack({4{32'hFC00_FC00}}, 0);
        // R2: junk bits on top of fields do not disturb them
        run_pack({4{32'hFFFF_FFFF}}, 0);
        // R8 pack
        run_pack({32'h1234_5678, 32'h0ABC_0DEF, 32'h0155_02AA, 32'h03FF_0000}, 1);

        // R5: blank page
        run_unpack({80{1'b1}}, 0, "R5");
        // R5/R6: one cleared bit is not blank
        run_unpack({{79{1'b1}}, 1'b0}, 0, "R6 near-blank symbols");
        run_unpack({1'b0, {79{1'b1}}}, 0, "R6 near-blank symbols");
        // R8 unpack
        run_unpack(80'h0123_4567_89AB_CDEF_1357, 1, "R6");

        // R9: random round trips
        for (int n = 0; n < 40; n++) begin
            logic [127:0] w;
            logic [79:0]  img;
            for (int k = 0; k < 4; k++) w[32*k +: 32] = $urandom();
            img = ref_image(w);
            run_pack(w, 0);
            if (img != {80{1'b1}}) begin
                @(negedge clk); up_start = 1'b1; up_bytes = pk_bytes;
                @(negedge clk); up_start = 1'b0;
                for (int k = 0; k < 8; k++) begin
                    @(negedge clk);
                    chk(up_sym_valid === 1'b1 && up_sym === ref_sym(w, 7 - k),
                        "R9 round trip", {69'd0, up_sym_valid, up_sym}, {69'd0, 1'b1, ref_sym(w, 7 - k)});
                end
                @(negedge clk);
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule